// File: doc/BRIEF.md
# Indirect-Access Interrupt Routing Register Window

This block holds the programmable state of an interrupt router behind a two-port window. The host first writes an internal register index into a select port, then reads or writes the chosen 32-bit register through a data port. Behind the window there are three registers: a unit identifier, a read-only version word that also reports how many routing entries exist, and an arbitration identifier. After them comes a table of 64-bit routing entries. Each entry is reached as two 32-bit halves at adjacent internal indices.

Each routing entry holds a vector, a delivery mode, a destination mode, a polarity, a trigger mode, a mask and a destination. The block drives every entry onto flat output buses, so the routing logic sees the current programming directly. Accesses to undefined internal indices have no effect and latch a sticky flag.

Top module: `irq_window_regs`

## Requirements
- R1: The select port is at byte offset 0. It holds an 8-bit internal index, which is taken from write data bits 7:0. A read of this port returns the index zero-extended to 32 bits. Reset clears the index to 0.
- R2: The data window is at byte offset 16. Read data appears on `rd_data` with `rd_valid` high in the cycle after the read request. Any other byte offset reads as 0 and ignores writes.
- R3: Index 0x00 holds the unit ID in bits 31:24, and reset loads it from `UNIT_ID`. Writes change only that field. All other bits read as 0.
- R4: Index 0x01 is read-only. It reads `(NENT-1)` in bits 23:16 and `VERSION` in bits 7:0, which gives 0x0017_0011 with the default parameters. Writes to it change nothing.
- R5: Index 0x02 holds the arbitration ID in bits 31:24. It is written and read like the unit ID, and reset loads it from `UNIT_ID`.
- R6: Entry i has its lower half at index 0x10+2i (even) and its upper half at 0x11+2i (odd). Lower half i drives `ent_lo_flat[32i+31:32i]` and upper half i drives `ent_hi_flat[32i+31:32i]`. These outputs change in the cycle after the write.
- R7: A write to an entry half clears the reserved bits of that half. The lower half keeps bits under the mask 0x0001_AFFF: vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, trigger mode 15 and mask 16. The upper half keeps only the destination, bits 31:24.
- R8: At reset every lower half is 0x0001_0000 (masked) and every upper half is 0.
- R9: Indices 0x03 to 0x0F, and indices from 0x10+2·NENT (0x40) upward, are undefined. A data-window read of one returns 0 and a write to one is ignored.
- R10: Any data-window access to an undefined index sets `bad_index` from the next cycle on. The flag stays set until reset. Accesses to defined indices and to the select port never set it.
- R11: A write to the data window changes only the register named by the current index. All other entries and registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset of the access (0 = select, 16 = window) |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| ent_lo_flat | output | NENT*32 | Lower halves of all entries, entry i at bits 32i+31:32i |
| ent_hi_flat | output | NENT*32 | Upper halves of all entries, entry i at bits 32i+31:32i |
| bad_index | output | 1 | Sticky flag: a window access named an undefined index |

## Verification
A read returns its data one cycle after the request. Writes appear on the entry buses, and on `bad_index`, in the cycle after the write edge. The bench drives each request at a falling edge and samples at the next falling edge, which lies after exactly one rising edge. There it compares `rd_data`, both entry buses and the flag against a bench model that has been updated by the same operation. Random select/read/write traffic is mixed with directed checks of the reset values, the version word, the reserved-bit clearing, the last entry and the first undefined index above the table.

// File: rtl/irq_window_regs.sv
module irq_window_regs #(
  parameter int NENT = 24,
  parameter logic [7:0] UNIT_ID = 8'h05,
  parameter logic [7:0] VERSION = 8'h11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [4:0]           req_addr,
  input  logic [31:0]          req_wdata,
  output logic                 rd_valid,
  output logic [31:0]          rd_data,
  output logic [NENT*32-1:0]   ent_lo_flat,
  output logic [NENT*32-1:0]   ent_hi_flat,
  output logic                 bad_index
);
  localparam int EW = $clog2(NENT);
  localparam logic [8:0] END_IDX = 9'(16 + 2 * NENT);
  localparam logic [31:0] LO_KEEP = 32'h0001_AFFF;
  localparam logic [31:0] HI_KEEP = 32'hFF00_0000;
  localparam logic [31:0] LO_RST  = 32'h0001_0000;

  logic [7:0]  sel_q, id_q, arb_q;
  logic [31:0] lo_q [NENT];
  logic [31:0] hi_q [NENT];
  logic [31:0] rmux;

  wire at_sel = (req_addr == 5'd0);
  wire at_win = (req_addr == 5'd16);
  wire is_ent = (sel_q >= 8'h10) && ({1'b0, sel_q} < END_IDX);
  wire defined = (sel_q <= 8'h02) || is_ent;
  wire [7:0] rel = sel_q - 8'h10;
  wire [EW-1:0] ent_idx = EW'(rel[7:1]);
  wire wr = req_valid && req_write;

  always_comb begin
    rmux = 32'h0;
    if (at_sel) rmux = {24'h0, sel_q};
    else if (at_win) begin
      if (sel_q == 8'h00)      rmux = {id_q, 24'h0};
      else if (sel_q == 8'h01) rmux = {8'h0, 8'(NENT - 1), 8'h0, VERSION};
      else if (sel_q == 8'h02) rmux = {arb_q, 24'h0};
      else if (is_ent)         rmux = sel_q[0] ? hi_q[ent_idx] : lo_q[ent_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q     <= 8'h0;
      id_q      <= UNIT_ID;
      arb_q     <= UNIT_ID;
      rd_valid  <= 1'b0;
      rd_data   <= 32'h0;
      bad_index <= 1'b0;
      for (int i = 0; i < NENT; i++) begin
        lo_q[i] <= LO_RST;
        hi_q[i] <= 32'h0;
      end
    end else begin
      rd_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rd_data <= rmux;
      if (req_valid && at_win && !defined) bad_index <= 1'b1;
      if (wr && at_sel) sel_q <= req_wdata[7:0];
      if (wr && at_win) begin
        if (sel_q == 8'h00)      id_q  <= req_wdata[31:24];
        else if (sel_q == 8'h02) arb_q <= req_wdata[31:24];
        else if (is_ent) begin
          if (sel_q[0]) hi_q[ent_idx] <= req_wdata & HI_KEEP;
          else          lo_q[ent_idx] <= req_wdata & LO_KEEP;
        end
      end
    end
  end

  for (genvar g = 0; g < NENT; g++) begin : g_flat
    assign ent_lo_flat[32*g +: 32] = lo_q[g];
    assign ent_hi_flat[32*g +: 32] = hi_q[g];
  end
endmodule

// File: rtl/irq_window_regs_chk.sv
module irq_window_regs_chk #(
  parameter int NENT = 24,
  parameter logic [7:0] VERSION = 8'h11
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [4:0]         req_addr,
  input logic               rd_valid,
  input logic [31:0]        rd_data,
  input logic [NENT*32-1:0] ent_lo_flat,
  input logic [NENT*32-1:0] ent_hi_flat,
  input logic               bad_index,
  input logic [7:0]         sel
);
  function automatic logic clean(input logic [NENT*32-1:0] lo, input logic [NENT*32-1:0] hi);
    logic ok = 1'b1;
    for (int i = 0; i < NENT; i++) begin
      if ((lo[32*i +: 32] & ~32'h0001_AFFF) != 32'h0) ok = 1'b0;
      if ((hi[32*i +: 32] & ~32'hFF00_0000) != 32'h0) ok = 1'b0;
    end
    return ok;
  endfunction

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && !req_write) |=> rd_valid); // R2
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) clean(ent_lo_flat, ent_hi_flat)); // R7
  AST_VERSION_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == 5'd16 && sel == 8'h01) |=> rd_data == {8'h0, 8'(NENT - 1), 8'h0, VERSION}); // R4
  AST_SEL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == 5'd0) |=> rd_data == {24'h0, $past(sel)}); // R1
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) bad_index |=> bad_index); // R10
  AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> ($stable(ent_lo_flat) && $stable(ent_hi_flat))); // R11
endmodule

bind irq_window_regs irq_window_regs_chk #(.NENT(NENT), .VERSION(VERSION)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .rd_valid(rd_valid), .rd_data(rd_data),
  .ent_lo_flat(ent_lo_flat), .ent_hi_flat(ent_hi_flat),
  .bad_index(bad_index), .sel(sel_q)
);

// File: tb/irq_window_regs_bench.sv
`timescale 1ns/1ps
module irq_window_regs_bench;
  localparam int NENT = 24;
  localparam logic [7:0] UID = 8'h05;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [4:0] req_addr = 5'd0;
  logic [31:0] req_wdata = 32'h0;
  logic rd_valid, bad_index;
  logic [31:0] rd_data;
  logic [NENT*32-1:0] ent_lo_flat, ent_hi_flat;

  irq_window_regs u_irq_window_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .ent_lo_flat(ent_lo_flat), .ent_hi_flat(ent_hi_flat),
    .bad_index(bad_index)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0] m_sel, m_id, m_arb;
  logic [31:0] m_lo [NENT];
  logic [31:0] m_hi [NENT];
  logic m_bad;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic m_defined();
    return (m_sel <= 8'h02) || (m_sel >= 8'h10 && int'(m_sel) < 16 + 2 * NENT);
  endfunction

  function automatic logic [31:0] m_read(input logic [4:0] a);
    int e;
    if (a == 5'd0) return {24'h0, m_sel};
    if (a != 5'd16) return 32'h0;
    if (m_sel == 8'h00) return {m_id, 24'h0};
    if (m_sel == 8'h01) return 32'h0017_0011;
    if (m_sel == 8'h02) return {m_arb, 24'h0};
    if (!m_defined()) return 32'h0;
    e = (int'(m_sel) - 16) / 2;
    return m_sel[0] ? m_hi[e] : m_lo[e];
  endfunction

  task automatic m_write(input logic [4:0] a, input logic [31:0] d);
    int e;
    if (a == 5'd0) m_sel = d[7:0];
    else if (a == 5'd16) begin
      if (!m_defined()) m_bad = 1'b1;
      else if (m_sel == 8'h00) m_id = d[31:24];
      else if (m_sel == 8'h02) m_arb = d[31:24];
      else if (m_sel >= 8'h10) begin
        e = (int'(m_sel) - 16) / 2;
        if (m_sel[0]) m_hi[e] = d & 32'hFF00_0000;
        else m_lo[e] = d & 32'h0001_AFFF;
      end
    end
  endtask

  task automatic cmp_table(input string tag);
    logic ok = 1'b1;
    for (int i = 0; i < NENT; i++)
      if (ent_lo_flat[32*i +: 32] != m_lo[i] || ent_hi_flat[32*i +: 32] != m_hi[i]) ok = 1'b0;
    chk(ok, tag, 32'(ok), 32'h1);
    chk(bad_index == m_bad, "R10 flag", 32'(bad_index), 32'(m_bad));
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    if (a == 5'd16 && !m_defined()) m_bad = 1'b1;
    m_write(a, d);
    cmp_table("R6/R11 table after write");
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    logic [31:0] exp;
    exp = m_read(a);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rd_valid, "R2 rd_valid", 32'(rd_valid), 32'h1);
    chk(rd_data == exp, tag, rd_data, exp);
    if (a == 5'd16 && !m_defined()) m_bad = 1'b1;
    chk(bad_index == m_bad, "R10 flag after read", 32'(bad_index), 32'(m_bad));
  endtask

  initial begin
    #(5.0 * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    m_sel = 8'h0; m_id = UID; m_arb = UID; m_bad = 1'b0;
    for (int i = 0; i < NENT; i++) begin m_lo[i] = 32'h0001_0000; m_hi[i] = 32'h0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_table("R8 reset table");
    rd(5'd0, "R1 reset select");
    rd(5'd16, "R3 reset unit id");
    wr(5'd16, 32'hA5FF_FFFF);
    rd(5'd16, "R3 unit id field only");
    wr(5'd0, 32'hFFFF_FF01);
    rd(5'd0, "R1 select low byte");
    rd(5'd16, "R4 version word");
    wr(5'd16, 32'hFFFF_FFFF);
    rd(5'd16, "R4 version write ignored");
    wr(5'd0, 32'h2);
    rd(5'd16, "R5 reset arb id");
    wr(5'd16, 32'h3C12_3456);
    rd(5'd16, "R5 arb id write");
    wr(5'd0, 32'h10);
    wr(5'd16, 32'hFFFF_FFFF);
    rd(5'd16, "R7 lower reserved cleared");
    wr(5'd0, 32'h11);
    wr(5'd16, 32'hFFFF_FFFF);
    rd(5'd16, "R7 upper reserved cleared");
    wr(5'd0, 32'h3F);
    wr(5'd16, 32'h9900_0000);
    rd(5'd16, "R6 last entry upper");
    rd(5'd8, "R2 other offset reads zero");
    wr(5'd8, 32'hFFFF_FFFF);
    rd(5'd0, "R2 other offset write ignored");
    chk(bad_index == 1'b0, "R10 flag clear before undefined", 32'(bad_index), 32'h0);
    wr(5'd0, 32'h40);
    wr(5'd16, 32'hFFFF_FFFF);
    rd(5'd16, "R9 index 0x40 reads zero");
    wr(5'd0, 32'h07);
    rd(5'd16, "R9 index 0x07 reads zero");
    for (int n = 0; n < 600; n++) begin
      int k = $urandom_range(0, 9);
      if (k < 3) wr(5'd0, {$urandom(), 8'($urandom_range(0, 71))} >> 0 & 32'hFFFF_FF00 | 32'($urandom_range(0, 71)));
      else if (k < 6) wr(5'd16, $urandom());
      else if (k < 9) rd(5'd16, "R6/R9 random window read");
      else rd(5'd0, "R1 random select read");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule